// File: doc/BRIEF.md
# External Bus Burst Transfer Sequencer

This block takes one internal transfer request at a time and plays it out on an external port that may be narrower than the request. The number of beats is set by the pair of transfer size and port size. Each beat moves one port width of data. When bursting is allowed, all beats share a single address phase. The size output then keeps the code of the whole transfer, and the beats follow one another at a programmable later-beat wait. When bursting is off, each beat becomes an independent bus cycle. Each such cycle has its own address phase and its own first-access wait, and the size output shows the port's own size.

Timing is built from four phases: address setup (one or two clocks, strobed by the address latch output), data (the programmed wait count, then termination), an optional extra hold clock, and a return to idle. Termination happens internally once the wait count has run out. In external-acknowledge mode, the acknowledge input must also be high, so an external agent can stretch any beat. All configuration is captured when a request is taken. A request is taken only while the sequencer is idle. A single-clock done pulse closes each transfer.

Top module: `bus_burst_seq`

## Requirements
- R1: The beat count depends on the port size code (01 = 8-bit, 10 or 11 = 16-bit, 00 = 32-bit) and the transfer size code (01 = byte, 10 = word, 00 = longword, 11 = 16-byte line). The counts are: on an 8-bit port, word 2, longword 4, line 16. On a 16-bit port, longword 2, line 8. On a 32-bit port, line 4. Any transfer that fits the port takes exactly 1 beat, whatever burstEn is.
- R2: With burstEn high and more than one beat, the whole transfer uses one address phase. burstOut is high and sizeOut equals the requested size code on every acknowledged beat.
- R3: With burstEn low and more than one beat, every beat is a separate bus cycle with its own address phase. On every beat, sizeOut shows the port's own size code: 01 for 8-bit, 10 for 16-bit, 00 for 32-bit. burstOut stays low.
- R4: The first beat's address is reqAddr. After each acknowledged beat, beatAddr rises by the port width in bytes (1, 2 or 4).
- R5: Counted from the first setup clock, the first beat of each bus cycle is acknowledged in clock S+firstWait+1, where S is the number of setup clocks. Each later beat of a burst follows the previous one after nextWait+1 clocks. So firstWait=1 with nextWait=0 gives a 3-1-1-1 pattern.
- R6: With extAckEn high, a beat ends only in a data clock where the wait count has expired and extAck is high. While extAck is low, dataStrobe stays high and beatAddr is held.
- R7: setupLong makes ale high for two clocks per address phase instead of one. holdLong inserts one clock with neither ale nor dataStrobe after every bus cycle.
- R8: done is high for exactly one clock. That clock follows the final acknowledge, or follows the hold clock when holdLong is set. busy is low while done is high.
- R9: A request is accepted only while busy is low. reqValid and all configuration inputs are ignored during a transfer, because their values are captured at acceptance.
- R10: After reset, busy, ale, dataStrobe, beatAck and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transfer request, taken when idle |
| reqAddr | input | ADDR_W | Start byte address |
| reqSize | input | 2 | Transfer size code |
| portSize | input | 2 | Port size code |
| burstEn | input | 1 | Allow burst cycles |
| firstWait | input | WAIT_W | Wait clocks for the first beat of a bus cycle |
| nextWait | input | WAIT_W | Wait clocks for each later burst beat |
| extAckEn | input | 1 | Require external acknowledge for termination |
| extAck | input | 1 | External transfer acknowledge |
| setupLong | input | 1 | Two-clock address setup |
| holdLong | input | 1 | Extra address hold clock after each bus cycle |
| busy | output | 1 | Transfer in progress |
| ale | output | 1 | Address latch strobe (setup phase) |
| dataStrobe | output | 1 | Data phase active |
| beatAck | output | 1 | Current beat terminates this clock |
| burstOut | output | 1 | Current transfer runs as a burst |
| sizeOut | output | 2 | Size code driven on the bus |
| beatAddr | output | ADDR_W | Address of the current beat |
| done | output | 1 | One-clock end-of-transfer pulse |

## Verification
The properties assume that extAck is only meaningful during a data clock, and that configuration inputs may change freely once a request has been taken. The bench keeps to this. It holds extAck either constantly high or low until it chooses a beat's end. It deliberately scrambles every configuration input and raises a stray request right after acceptance. The properties also assume reqValid can be high at any time. The bench raises it only when idle or as an intentional busy-time probe.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int BEAT_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP1,
    ST_SETUP2,
    ST_DATA,
    ST_HOLD
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic loadFirst;
    logic loadNext;
    logic countDown;
    logic advance;
  } seqStrobes_t;

  // number of beats for a port/transfer size pair
  function automatic logic [BEAT_W-1:0] beatsFor(input logic [1:0] port, input logic [1:0] size);
    logic [BEAT_W-1:0] n;
    n = BEAT_W'(1);
    if (port == 2'b01) begin
      case (size)
        2'b10:   n = BEAT_W'(2);
        2'b00:   n = BEAT_W'(4);
        2'b11:   n = BEAT_W'(16);
        default: n = BEAT_W'(1);
      endcase
    end else if (port[1]) begin
      case (size)
        2'b00:   n = BEAT_W'(2);
        2'b11:   n = BEAT_W'(8);
        default: n = BEAT_W'(1);
      endcase
    end else if (port == 2'b00) begin
      n = (size == 2'b11) ? BEAT_W'(4) : BEAT_W'(1);
    end
    return n;
  endfunction

  function automatic logic [2:0] portBytes(input logic [1:0] port);
    if (port == 2'b01) return 3'd1;
    if (port[1])       return 3'd2;
    return 3'd4;
  endfunction

  function automatic logic [1:0] portSizeCode(input logic [1:0] port);
    if (port == 2'b01) return 2'b01;
    if (port[1])       return 2'b10;
    return 2'b00;
  endfunction

endpackage

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [1:0]        portSize,
  input  logic              burstEn,
  input  logic [WAIT_W-1:0] firstWait,
  input  logic [WAIT_W-1:0] nextWait,
  input  logic              extAckEn,
  input  logic              setupLong,
  input  logic              holdLong,
  output logic [ADDR_W-1:0] beatAddr,
  output logic [1:0]        sizeOut,
  output logic              burstOut,
  output logic              waitZero,
  output logic              lastBeat,
  output logic              allDone,
  output logic              cfgExt,
  output logic              cfgSetupLong,
  output logic              cfgHoldLong
);

  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        sizeQ, portQ;
  logic              burstQ, splitQ, extQ, setupQ, holdQ;
  logic [WAIT_W-1:0] firstQ, nextQ, waitQ;
  logic [BEAT_W-1:0] leftQ;
  logic [BEAT_W-1:0] reqBeats;

  assign reqBeats = beatsFor(portSize, reqSize);

  // request capture and beat advance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      sizeQ  <= '0;
      portQ  <= '0;
      burstQ <= 1'b0;
      splitQ <= 1'b0;
      extQ   <= 1'b0;
      setupQ <= 1'b0;
      holdQ  <= 1'b0;
      firstQ <= '0;
      nextQ  <= '0;
      leftQ  <= '0;
    end else if (stb.capture) begin
      addrQ  <= reqAddr;
      sizeQ  <= reqSize;
      portQ  <= portSize;
      burstQ <= burstEn && (reqBeats > BEAT_W'(1));
      splitQ <= !burstEn && (reqBeats > BEAT_W'(1));
      extQ   <= extAckEn;
      setupQ <= setupLong;
      holdQ  <= holdLong;
      firstQ <= firstWait;
      nextQ  <= nextWait;
      leftQ  <= reqBeats;
    end else if (stb.advance) begin
      addrQ <= addrQ + ADDR_W'(portBytes(portQ));
      leftQ <= leftQ - BEAT_W'(1);
    end
  end

  // wait-state counter
  always_ff @(posedge clk) begin
    if (!rstN)              waitQ <= '0;
    else if (stb.loadFirst) waitQ <= firstQ;
    else if (stb.loadNext)  waitQ <= nextQ;
    else if (stb.countDown) waitQ <= waitQ - WAIT_W'(1);
  end

  assign beatAddr     = addrQ;
  assign sizeOut      = splitQ ? portSizeCode(portQ) : sizeQ;
  assign burstOut     = burstQ;
  assign waitZero     = (waitQ == '0);
  assign lastBeat     = (leftQ == BEAT_W'(1));
  assign allDone      = (leftQ == '0);
  assign cfgExt       = extQ;
  assign cfgSetupLong = setupQ;
  assign cfgHoldLong  = holdQ;

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        extAck,
  input  logic        waitZero,
  input  logic        lastBeat,
  input  logic        allDone,
  input  logic        cfgBurst,
  input  logic        cfgExt,
  input  logic        cfgSetupLong,
  input  logic        cfgHoldLong,
  output seqStrobes_t stb,
  output logic        ale,
  output logic        dataStrobe,
  output logic        beatAck,
  output logic        busy,
  output logic        done
);

  seqState_t state, nextState;
  logic      finish;

  assign beatAck    = (state == ST_DATA) && waitZero && (!cfgExt || extAck);
  assign ale        = (state == ST_SETUP1) || (state == ST_SETUP2);
  assign dataStrobe = (state == ST_DATA);
  assign busy       = (state != ST_IDLE);

  always_comb begin
    nextState = state;
    stb       = '0;
    finish    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.capture = 1'b1;
          nextState   = ST_SETUP1;
        end
      end
      ST_SETUP1: begin
        stb.loadFirst = 1'b1;
        nextState     = cfgSetupLong ? ST_SETUP2 : ST_DATA;
      end
      ST_SETUP2: begin
        stb.loadFirst = 1'b1;
        nextState     = ST_DATA;
      end
      ST_DATA: begin
        if (beatAck) begin
          stb.advance = 1'b1;
          if (lastBeat) begin
            nextState = cfgHoldLong ? ST_HOLD : ST_IDLE;
            finish    = !cfgHoldLong;
          end else if (cfgBurst) begin
            stb.loadNext = 1'b1;
          end else begin
            nextState = cfgHoldLong ? ST_HOLD : ST_SETUP1;
          end
        end else begin
          stb.countDown = !waitZero;
        end
      end
      ST_HOLD: begin
        nextState = allDone ? ST_IDLE : ST_SETUP1;
        finish    = allDone;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= finish;
    end
  end

endmodule

// File: rtl/bus_burst_seq.sv
module bus_burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [1:0]        portSize,
  input  logic              burstEn,
  input  logic [WAIT_W-1:0] firstWait,
  input  logic [WAIT_W-1:0] nextWait,
  input  logic              extAckEn,
  input  logic              extAck,
  input  logic              setupLong,
  input  logic              holdLong,
  output logic              busy,
  output logic              ale,
  output logic              dataStrobe,
  output logic              beatAck,
  output logic              burstOut,
  output logic [1:0]        sizeOut,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              done
);

  seqStrobes_t stb;
  logic waitZero, lastBeat, allDone, cfgExt, cfgSetupLong, cfgHoldLong;

  burst_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .extAck       (extAck),
    .waitZero     (waitZero),
    .lastBeat     (lastBeat),
    .allDone      (allDone),
    .cfgBurst     (burstOut),
    .cfgExt       (cfgExt),
    .cfgSetupLong (cfgSetupLong),
    .cfgHoldLong  (cfgHoldLong),
    .stb          (stb),
    .ale          (ale),
    .dataStrobe   (dataStrobe),
    .beatAck      (beatAck),
    .busy         (busy),
    .done         (done)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .reqAddr      (reqAddr),
    .reqSize      (reqSize),
    .portSize     (portSize),
    .burstEn      (burstEn),
    .firstWait    (firstWait),
    .nextWait     (nextWait),
    .extAckEn     (extAckEn),
    .setupLong    (setupLong),
    .holdLong     (holdLong),
    .beatAddr     (beatAddr),
    .sizeOut      (sizeOut),
    .burstOut     (burstOut),
    .waitZero     (waitZero),
    .lastBeat     (lastBeat),
    .allDone      (allDone),
    .cfgExt       (cfgExt),
    .cfgSetupLong (cfgSetupLong),
    .cfgHoldLong  (cfgHoldLong)
  );

endmodule

// File: rtl/burst_seq_checker.sv
module burst_seq_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              ale,
  input logic              dataStrobe,
  input logic              beatAck,
  input logic              burstOut,
  input logic [1:0]        sizeOut,
  input logic [ADDR_W-1:0] beatAddr,
  input logic              done
);

  // R7: address phase and data phase never overlap
  p_phase_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(ale && dataStrobe));

  // R2: size code held between consecutive burst data clocks
  p_burst_size_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dataStrobe && burstOut) |=> (!dataStrobe || $stable(sizeOut)));

  // R4: an acknowledged beat moves the beat address
  p_addr_advance_r4: assert property (@(posedge clk) disable iff (!rstN)
    beatAck |=> (beatAddr != $past(beatAddr)));

  // R6: without acknowledge the address holds during a transfer
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !beatAck) |=> $stable(beatAddr));

  // R8: done lasts one clock and only while idle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R5: termination happens only in a data clock
  p_ack_in_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    beatAck |-> dataStrobe);

  // R9: each transfer opens with an address phase
  p_start_setup_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ale);

endmodule

bind bus_burst_seq burst_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .ale        (ale),
  .dataStrobe (dataStrobe),
  .beatAck    (beatAck),
  .burstOut   (burstOut),
  .sizeOut    (sizeOut),
  .beatAddr   (beatAddr),
  .done       (done)
);

// File: tb/test_bus_burst_seq.sv
module test_bus_burst_seq;

  localparam int ADDR_W = 32;
  localparam int WAIT_W = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0]        reqSize = '0;
  logic [1:0]        portSize = '0;
  logic              burstEn = 1'b0;
  logic [WAIT_W-1:0] firstWait = '0;
  logic [WAIT_W-1:0] nextWait = '0;
  logic              extAckEn = 1'b0;
  logic              extAck = 1'b0;
  logic              setupLong = 1'b0;
  logic              holdLong = 1'b0;
  logic              busy, ale, dataStrobe, beatAck, burstOut, done;
  logic [1:0]        sizeOut;
  logic [ADDR_W-1:0] beatAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bus_burst_seq #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) i_bus_burst_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .portSize(portSize), .burstEn(burstEn),
    .firstWait(firstWait), .nextWait(nextWait), .extAckEn(extAckEn),
    .extAck(extAck), .setupLong(setupLong), .holdLong(holdLong),
    .busy(busy), .ale(ale), .dataStrobe(dataStrobe), .beatAck(beatAck),
    .burstOut(burstOut), .sizeOut(sizeOut), .beatAddr(beatAddr), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expBeats(input logic [1:0] port, input logic [1:0] size);
    int bytesT, bytesP;
    bytesT = (size == 2'b01) ? 1 : (size == 2'b10) ? 2 : (size == 2'b00) ? 4 : 16;
    bytesP = (port == 2'b01) ? 1 : port[1] ? 2 : 4;
    return (bytesT <= bytesP) ? 1 : bytesT / bytesP;
  endfunction

  // one transfer with full timing and address checks
  task automatic do_xfer(input logic [31:0] addr, input logic [1:0] size,
                         input logic [1:0] port, input bit burst,
                         input int fw, input int nw, input bit sL,
                         input bit hL, input bit ext, input string name);
    int beats, step, busCycles, S, H, aleCnt, ackCnt, expAck, doneCyc;
    bit isBurst;
    logic [1:0] expSize;
    beats     = expBeats(port, size);
    step      = (port == 2'b01) ? 1 : port[1] ? 2 : 4;
    isBurst   = burst && (beats > 1);
    busCycles = isBurst ? 1 : beats;
    S         = sL ? 2 : 1;
    H         = hL ? 1 : 0;
    expSize   = (beats > 1 && !burst) ? ((port == 2'b01) ? 2'b01 : port[1] ? 2'b10 : 2'b00) : size;
    aleCnt = 0; ackCnt = 0; doneCyc = -1;
    expAck = S + fw + 1;

    @(negedge clk);
    reqValid  = 1'b1; reqAddr = addr; reqSize = size; portSize = port;
    burstEn   = burst; firstWait = WAIT_W'(fw); nextWait = WAIT_W'(nw);
    extAckEn  = ext; extAck = ext; setupLong = sL; holdLong = hL;
    @(posedge clk);
    for (int cyc = 1; cyc < 400; cyc++) begin
      @(negedge clk);
      if (cyc == 1) begin
        // R9: scramble configuration and raise a stray request while busy
        reqSize = ~size; portSize = ~port; burstEn = ~burst;
        firstWait = WAIT_W'(9); nextWait = WAIT_W'(7);
        setupLong = ~sL; holdLong = ~hL; extAckEn = ~ext;
        reqAddr = 32'hDEAD_0000;
      end
      if (ale) aleCnt++;
      if (beatAck) begin
        chk(beatAddr == addr + 32'(ackCnt * step), "R4", {name, " beat address"},
            beatAddr, addr + ackCnt * step);
        chk(sizeOut == expSize, isBurst ? "R2" : "R3", {name, " size code"}, sizeOut, expSize);
        chk(burstOut == isBurst, isBurst ? "R2" : "R3", {name, " burst flag"}, burstOut, isBurst);
        chk(cyc == expAck, "R5", {name, " ack clock"}, cyc, expAck);
        ackCnt++;
        expAck = isBurst ? cyc + nw + 1 : cyc + H + S + fw + 1;
      end
      if (cyc == 1) reqValid = 1'b1;
      else          reqValid = 1'b0;
      if (done) begin
        chk(!busy, "R8", {name, " busy with done"}, busy, 0);
        doneCyc = cyc;
        break;
      end
    end
    chk(ackCnt == beats, "R1", {name, " beat count"}, ackCnt, beats);
    chk(aleCnt == busCycles * S, "R7", {name, " address phase clocks"}, aleCnt, busCycles * S);
    chk(doneCyc == expAck - (isBurst ? nw + 1 : H + S + fw + 1) + H + 1, "R8",
        {name, " done clock"}, doneCyc, expAck - (isBurst ? nw + 1 : H + S + fw + 1) + H + 1);
    @(negedge clk);
    chk(!done && !busy, "R9", {name, " idle after done"}, {done, busy}, 0);
    extAckEn = 1'b0; extAck = 1'b0;
  endtask

  // external acknowledge holds off termination
  task automatic t_ext_hold();
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'h40; reqSize = 2'b00; portSize = 2'b00;
    burstEn = 1'b1; firstWait = WAIT_W'(1); nextWait = '0;
    extAckEn = 1'b1; extAck = 1'b0; setupLong = 1'b0; holdLong = 1'b0;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(ale == 1'b1, "R6", "ext setup clock", ale, 1);
    for (int c = 2; c <= 6; c++) begin
      @(negedge clk);
      chk(dataStrobe && !beatAck && beatAddr == 32'h40, "R6", "ext held beat",
          {dataStrobe, beatAck}, 2);
    end
    extAck = 1'b1;
    #1;
    chk(beatAck == 1'b1, "R6", "ext ack ends beat", beatAck, 1);
    @(negedge clk);
    chk(done == 1'b1, "R8", "ext done pulse", done, 1);
    extAck = 1'b0; extAckEn = 1'b0;
    @(negedge clk);
    chk(!done && !busy, "R8", "ext done single clock", {done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk({busy, ale, dataStrobe, beatAck, done} == 5'b0, "R10", "reset outputs",
        {busy, ale, dataStrobe, beatAck, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({busy, ale, dataStrobe, done} == 4'b0, "R10", "idle after reset",
        {busy, ale, dataStrobe, done}, 0);

    do_xfer(32'h100, 2'b10, 2'b01, 1, 1, 0, 0, 0, 0, "burst word 8-bit");
    do_xfer(32'h200, 2'b11, 2'b00, 1, 1, 0, 0, 0, 0, "burst line 32-bit 3-1-1-1");
    do_xfer(32'h300, 2'b11, 2'b10, 0, 0, 0, 0, 1, 0, "split line 16-bit hold");
    do_xfer(32'h400, 2'b00, 2'b01, 1, 2, 2, 1, 0, 0, "burst long 8-bit slow");
    do_xfer(32'h500, 2'b11, 2'b01, 1, 0, 1, 0, 1, 0, "burst line 8-bit");
    do_xfer(32'h600, 2'b10, 2'b01, 0, 1, 3, 1, 1, 0, "split word 8-bit");
    do_xfer(32'h700, 2'b00, 2'b11, 0, 2, 0, 0, 0, 0, "split long 16-bit");
    do_xfer(32'h800, 2'b00, 2'b00, 1, 0, 0, 0, 0, 0, "fit long 32-bit burst");
    do_xfer(32'h900, 2'b10, 2'b10, 0, 1, 0, 0, 0, 0, "fit word 16-bit");
    do_xfer(32'hA00, 2'b01, 2'b01, 1, 0, 0, 1, 1, 0, "fit byte 8-bit");
    do_xfer(32'hB00, 2'b00, 2'b10, 1, 2, 1, 0, 0, 1, "burst long ext tied");
    t_ext_hold();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule